// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is one interval-timer channel behind a byte-wide register port. Software loads a preload value, picks one of four tick sources and starts the channel. The counter then steps down by one on each tick of the chosen source. When a tick arrives while the count is zero, the channel does four things:

- it reloads the preload value;
- it sets a sticky terminal-count flag;
- it drives a one-cycle rising-edge interrupt pulse;
- it keeps running.

The slow tick sources arrive as single-cycle enable strobes from clock generators outside the block. The fastest source is the block clock itself.

Combined mode sends every terminal-count pulse out on a chain output. A following channel can then use that pulse as its own tick.

The observation register gives the live count. It is read as four bytes. Reading the lowest byte captures the upper three bytes, so a multi-byte read never mixes two counter values.

Top module: `itmr_top`

## Requirements
- R1: After reset, every readable register reads 0x00, the count is 0, and `irq_o` and `chain_o` are low.
- R2: Control sits at address 0 (bit 0 run, bit 1 restart, bit 3 combine, bit 7 read-only terminal flag; restart always reads 0). The tick select sits at address 1, bits [1:0]. The preload sits at addresses 4..7, least significant byte first. Unmapped addresses read 0x00.
- R3: A control write with bit 1 set loads the count from the preload on that write's clock edge. This load takes priority over a tick in the same cycle.
- R4: Tick select 0, 1 and 2 choose `tick_32k_i`, `tick_1k_i` and `tick_32_i`. Select 3 ticks on every clock. While running, each selected tick lowers the count by one.
- R5: A tick at count zero reloads the preload, so a preload of N gives a period of N+1 ticks. It also raises `irq_o` for exactly one cycle.
- R6: The terminal flag is set at terminal count. A read of address 0 returns the flag in bit 7 and clears it. A terminal count in the same cycle as that read leaves the flag set.
- R7: Clearing the run bit freezes the count at its present value. Ticks then have no effect.
- R8: With a preload of zero, the channel stays idle. The count holds, and no interrupt or flag is produced.
- R9: A read of address 8 returns the live count bits [7:0] and captures the count. Reads of addresses 9..11 return bits [15:8], [23:16] and [31:24] of that captured value.
- R10: `chain_o` pulses together with `irq_o` only while the combine bit is set.
- R11: With `CNT_W` of 24, preload bits 31..24 are not stored and address 7 reads 0x00. `CNT_W` may only be 24 or 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the fastest tick source |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_32k_i | input | 1 | Enable strobe of the 32.768 kHz source |
| tick_1k_i | input | 1 | Enable strobe of the 1.024 kHz source |
| tick_32_i | input | 1 | Enable strobe of the 32 Hz source |
| bus_addr_i | input | 4 | Register byte address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe; side effects occur on the clock edge |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from the address |
| irq_o | output | 1 | One-cycle terminal-count interrupt pulse |
| chain_o | output | 1 | Terminal-count pulse to the next channel in combined mode |

## Verification
The bench sweeps preloads 1 to 6 on the every-clock source and measures the gap between interrupt pulses. A design that reloaded one tick late or early would show a gap other than N+1.

Each slow tick line is pulsed a different number of times under each select. A swapped select decode therefore leaves the wrong remainder in the count.

Further cases cover:
- a torn observation read, where a tick falls between the byte reads;
- a flag that clears on the wrong access;
- a stopped counter that still moves on ticks;
- a zero preload that fires endlessly;
- chain pulses leaking out without the combine bit.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
   localparam int ADDR_W = 4;
   localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
   localparam logic [ADDR_W-1:0] A_TSEL = 4'd1;
   localparam logic [ADDR_W-1:0] A_PRE0 = 4'd4;
   localparam logic [ADDR_W-1:0] A_OBS0 = 4'd8;
   localparam int B_RUN  = 0;
   localparam int B_RST  = 1;
   localparam int B_COMB = 3;
   localparam int B_FLAG = 7;

   typedef enum logic [1:0] {
      TS_32K  = 2'd0,
      TS_1K   = 2'd1,
      TS_32   = 2'd2,
      TS_FAST = 2'd3
   } tsel_e;
endpackage

// File: rtl/itmr_tick_sel.sv
module itmr_tick_sel
   import itmr_pkg::*;
#(
   parameter int N_SLOW = 3
) (
   input  logic [N_SLOW-1:0] slow_i,
   input  tsel_e             sel_i,
   output logic              tick_o
);
   localparam int SEL_W = $clog2(N_SLOW + 1);

   logic [N_SLOW:0] src;

   generate
      for (genvar g = 0; g < N_SLOW; g++) begin : g_src
         assign src[g] = slow_i[g];
      end
   endgenerate
   assign src[N_SLOW] = 1'b1;

   assign tick_o = src[SEL_W'(sel_i)];

   generate
      if (SEL_W != 2) begin : g_bad_sel
         $error("itmr_tick_sel: select width must be 2");
      end
   endgenerate
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en_i,
   input  logic         tick_i,
   input  logic         load_i,
   input  logic [W-1:0] preload_i,
   output logic [W-1:0] cnt_o,
   output logic         tc_o
);
   logic [W-1:0] cnt_q;
   logic         pre_ok;
   logic         step;

   assign pre_ok = (preload_i != '0);
   assign step   = en_i && tick_i && pre_ok && !load_i;
   assign tc_o   = step && (cnt_q == '0);
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (load_i)   cnt_q <= preload_i;
      else if (tc_o)     cnt_q <= preload_i;
      else if (step)     cnt_q <= cnt_q - 1'b1;
   end

   AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && !load_i) |=> $stable(cnt_q)) else $error("freeze"); // R7
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (preload_i == '0 && !load_i) |=> $stable(cnt_q)) else $error("idle"); // R8
   AST_TC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      tc_o |=> (cnt_q == $past(preload_i))) else $error("reload"); // R5
   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)) else $error("step"); // R4
   AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_q == $past(preload_i))) else $error("load"); // R3
endmodule

// File: rtl/itmr_obs.sv
module itmr_obs (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [31:0] cnt_i,
   input  logic        cap_i,
   input  logic [1:0]  idx_i,
   output logic [7:0]  byte_o
);
   logic [23:0] lat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lat_q <= '0;
      else if (cap_i) lat_q <= cnt_i[31:8];
   end

   always_comb begin
      case (idx_i)
         2'd0:    byte_o = cnt_i[7:0];
         2'd1:    byte_o = lat_q[7:0];
         2'd2:    byte_o = lat_q[15:8];
         default: byte_o = lat_q[23:16];
      endcase
   end

   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_i |=> $stable(lat_q)) else $error("latch"); // R9
endmodule

// File: rtl/itmr_top.sv
module itmr_top
   import itmr_pkg::*;
#(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_32k_i,
   input  logic             tick_1k_i,
   input  logic             tick_32_i,
   input  logic [3:0]       bus_addr_i,
   input  logic             bus_wr_i,
   input  logic             bus_rd_i,
   input  logic [7:0]       bus_wdata_i,
   output logic [7:0]       bus_rdata_o,
   output logic             irq_o,
   output logic             chain_o
);
   localparam int NB = CNT_W / 8;

   generate
      if (!(CNT_W == 24 || CNT_W == 32)) begin : g_bad_w
         $error("itmr_top: CNT_W must be 24 or 32");
      end
   endgenerate

   logic             run_q, comb_q, flag_q, irq_q, chain_q;
   tsel_e            tsel_q;
   logic [CNT_W-1:0] pre_q;
   logic [CNT_W-1:0] cnt;
   logic [31:0]      cnt32, pre32;
   logic             tick, tc, load, wr_ctrl, rd_ctrl, obs_cap;
   logic [7:0]       obs_byte;

   assign wr_ctrl = bus_wr_i && bus_addr_i == A_CTRL;
   assign rd_ctrl = bus_rd_i && bus_addr_i == A_CTRL;
   assign load    = wr_ctrl && bus_wdata_i[B_RST];
   assign obs_cap = bus_rd_i && bus_addr_i == A_OBS0;
   assign cnt32   = 32'(cnt);
   assign pre32   = 32'(pre_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         comb_q <= 1'b0;
         tsel_q <= TS_32K;
         pre_q  <= '0;
      end else if (bus_wr_i) begin
         if (bus_addr_i == A_CTRL) begin
            run_q  <= bus_wdata_i[B_RUN];
            comb_q <= bus_wdata_i[B_COMB];
         end
         if (bus_addr_i == A_TSEL) tsel_q <= tsel_e'(bus_wdata_i[1:0]);
         for (int b = 0; b < NB; b++) begin
            if (bus_addr_i == A_PRE0 + 4'(b)) pre_q[8*b +: 8] <= bus_wdata_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q  <= 1'b0;
         irq_q   <= 1'b0;
         chain_q <= 1'b0;
      end else begin
         irq_q   <= tc;
         chain_q <= tc && comb_q;
         if (tc)           flag_q <= 1'b1;
         else if (rd_ctrl) flag_q <= 1'b0;
      end
   end

   itmr_tick_sel #(.N_SLOW(3)) u_tsel (
      .slow_i ({tick_32_i, tick_1k_i, tick_32k_i}),
      .sel_i  (tsel_q),
      .tick_o (tick)
   );

   itmr_counter #(.W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (run_q),
      .tick_i    (tick),
      .load_i    (load),
      .preload_i (pre_q),
      .cnt_o     (cnt),
      .tc_o      (tc)
   );

   itmr_obs u_obs (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt_i  (cnt32),
      .cap_i  (obs_cap),
      .idx_i  (bus_addr_i[1:0]),
      .byte_o (obs_byte)
   );

   always_comb begin
      bus_rdata_o = 8'h00;
      case (bus_addr_i[3:2])
         2'd0: begin
            if (bus_addr_i == A_CTRL)
               bus_rdata_o = {flag_q, 3'b000, comb_q, 2'b00, run_q};
            else if (bus_addr_i == A_TSEL)
               bus_rdata_o = {6'd0, tsel_q};
         end
         2'd1:    bus_rdata_o = pre32[8*bus_addr_i[1:0] +: 8];
         2'd2:    bus_rdata_o = obs_byte;
         default: bus_rdata_o = 8'h00;
      endcase
   end

   assign irq_o   = irq_q;
   assign chain_o = chain_q;

   AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |=> !irq_q) else $error("irq width"); // R5
   AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> flag_q) else $error("flag"); // R6
   AST_CHAIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      chain_q |-> (irq_q && comb_q)) else $error("chain"); // R10
endmodule

// File: tb/tb_itmr_top.sv
module tb_itmr_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] tk = '0;
   logic [3:0] addr = '0;
   logic       wr = 1'b0, rd = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq, chain;
   int         checks = 0, errors = 0;
   int         cyc = 0;

   always #2 clk = ~clk;
   always @(negedge clk) cyc++;

   itmr_top #(.CNT_W(24)) dut (
      .clk(clk), .rst_n(rst_n),
      .tick_32k_i(tk[0]), .tick_1k_i(tk[1]), .tick_32_i(tk[2]),
      .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .irq_o(irq), .chain_o(chain)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wreg(logic [3:0] a, logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic rreg(logic [3:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; rd = 1'b1;
      #1 d = rdata;
      @(negedge clk); rd = 1'b0;
   endtask

   task automatic pulse(int line, int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tk[line] = 1'b1;
         @(negedge clk); tk[line] = 1'b0;
      end
   endtask

   task automatic wait_irq(output int at);
      at = -1;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (irq) begin at = cyc; break; end
      end
   endtask

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] d, e;
      int t0, t1, ni, nc, bad;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 12; a++) begin
         rreg(4'(a), d);
         chk("R1 reset read", d, 0);
      end
      chk("R1 irq", irq, 0);
      chk("R1 chain", chain, 0);

      // R2 / R11 map and width
      wreg(4, 8'h11); wreg(5, 8'h22); wreg(6, 8'h33); wreg(7, 8'hAB);
      wreg(1, 8'hFE);
      rreg(4, d); chk("R2 pre byte0", d, 8'h11);
      rreg(5, d); chk("R2 pre byte1", d, 8'h22);
      rreg(6, d); chk("R2 pre byte2", d, 8'h33);
      rreg(7, d); chk("R11 pre byte3", d, 8'h00);
      rreg(1, d); chk("R2 tsel", d, 8'h02);
      rreg(2, d); chk("R2 unmapped", d, 8'h00);
      wreg(0, 8'h0A);
      rreg(0, d); chk("R2 ctrl restart reads 0", d, 8'h08);
      wreg(0, 8'h00);

      // R4 tick-select sweep: line k gets k+1 pulses
      for (int s = 0; s < 3; s++) begin
         wreg(0, 0); wreg(4, 100); wreg(5, 0); wreg(6, 0);
         wreg(1, 8'(s)); wreg(0, 8'h03);
         pulse(0, 1); pulse(1, 2); pulse(2, 3);
         rreg(8, d);
         chk("R4 select sweep", d, 100 - (s + 1));
      end

      // R3 restart loads on write edge
      wreg(0, 8'h03);
      rreg(8, d); chk("R3 restart reload", d, 100);

      // R5 period sweep on every-clock source
      wreg(0, 0); wreg(1, 3);
      rreg(0, d);
      for (int n = 1; n <= 6; n++) begin
         wreg(4, 8'(n)); wreg(0, 8'h03);
         wait_irq(t0);
         @(negedge clk);
         chk("R5 irq one cycle", irq, 0);
         wait_irq(t1);
         chk("R5 period", t1 - t0, n + 1);
         wreg(0, 0);
      end

      // R6 flag read and clear (stopped channel)
      rreg(0, d); chk("R6 flag set", d, 8'h80);
      rreg(0, d); chk("R6 flag cleared", d, 8'h00);

      // R7 freeze
      wreg(4, 200); wreg(0, 8'h03);
      repeat (5) @(negedge clk);
      wreg(0, 8'h00);
      rreg(8, d);
      repeat (10) @(negedge clk);
      pulse(0, 2);
      rreg(8, e);
      chk("R7 frozen", e, d);

      // R8 zero preload idles
      wreg(4, 0); wreg(5, 0); wreg(6, 0); wreg(0, 8'h03);
      ni = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (irq) ni++; end
      chk("R8 no irq", ni, 0);
      rreg(0, d); chk("R8 no flag", d, 8'h01);
      rreg(8, d); chk("R8 count held", d, 0);

      // R9 coherent observation
      wreg(0, 0); wreg(1, 0); wreg(4, 8'h00); wreg(5, 8'h03); wreg(0, 8'h03);
      rreg(8, d); chk("R9 low byte", d, 8'h00);
      pulse(0, 1);
      rreg(9, d); chk("R9 latched byte1", d, 8'h03);
      rreg(8, d); chk("R9 live low", d, 8'hFF);
      rreg(9, d); chk("R9 new byte1", d, 8'h02);
      rreg(10, d); chk("R9 byte2", d, 8'h00);

      // R10 chain with and without combine
      wreg(0, 0); wreg(1, 3); wreg(4, 2); wreg(5, 0); wreg(0, 8'h0B);
      ni = 0; nc = 0; bad = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (irq) ni++;
         if (chain) nc++;
         if (irq != chain) bad++;
      end
      chk("R10 chain follows irq", bad, 0);
      chk("R10 chain count", (nc >= 9) ? 1 : 0, 1);
      wreg(0, 8'h03);
      ni = 0; nc = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (irq) ni++;
         if (chain) nc++;
      end
      chk("R10 no chain", nc, 0);
      chk("R5 irq still runs", (ni >= 9) ? 1 : 0, 1);

      // R6 set wins over simultaneous read: preload 1 fires every 2 clocks
      wreg(4, 1); wreg(0, 8'h03);
      bad = 0;
      for (int i = 0; i < 6; i++) begin
         rreg(0, d);
         if (!d[7]) bad++;
      end
      chk("R6 set beats clear", bad, 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule